// File: doc/BRIEF.md
# Trap Level Stack with Done/Retry Return

This block keeps the nested trap context of a processor core. When a trap is taken, it pushes one entry onto a stack of trap levels. The entry holds the current condition codes, address-space identifier, processor state and window pointer packed into a single word, plus the program counter, the next program counter and the trap type. In the same step the block switches the processor state to the trap-handler mode and builds the handler vector from the trap base address. It then steers the program counter to that vector.

Two return strobes pop the top entry. `done` resumes at the instruction after the trapped one. `retry` re-executes the trapped instruction. Both restore the packed fields and lower the trap level. A trap taken while the stack is already full sets a sticky error-state flag. A return with an empty stack is reported as illegal. Neither of these changes any state.

The caller presents the current architectural state on the inputs. One cycle after an accepted operation, the block presents the new state on registered outputs together with an update pulse. Register-window contents are not held here.

Top module: `trap_stack`

## Requirements
- R1: After reset the trap level, all state outputs, the update pulse, the error flag and the illegal flag are zero.
- R2: On an accepted trap, the entry at the current level stores a word laid out as condition codes in bits [CC_W+31:32], address-space identifier in [31:24], zero in [23:20], processor state in [19:8] and window pointer in [7:0].
- R3: On an accepted trap, the processor state output becomes 0x015 (alternate globals bit 0, privileged bit 2, FP-enable bit 4, all other bits clear). Bit 5 (reset-error state) is also set when the level before the trap was MAX_TL-1 or higher.
- R4: On an accepted trap, the base output keeps the base input above bit 14, sets bit 14 when the level before the trap exceeds 1, places the 9-bit trap type in bits [13:5] and clears bits [4:0].
- R5: On an accepted trap, the program counter output equals the new base output and the next program counter output equals it plus 4. Condition codes, address-space identifier and window pointer pass through from the inputs.
- R6: A trap taken below MAX_TL raises the trap level by one and pulses `upd_o` one cycle later.
- R7: A trap taken at level MAX_TL sets `err_o`, which stays set until reset. Level and outputs are unchanged, and `upd_o` stays low.
- R8: A done return sets the program counter to the saved next program counter and the next program counter to that value plus 4.
- R9: A retry return sets the program counter to the saved program counter and the next program counter to the saved next program counter.
- R10: Both returns restore condition codes, address-space identifier, processor state and window pointer from the top saved word. They lower the level by one and leave the base output unchanged.
- R11: A return at level 0 pulses `illegal_o` one cycle later and changes no state.
- R12: When strobes coincide, a trap takes precedence over a done, and a done takes precedence over a retry.
- R13: `tt_o` shows the trap type saved at the top level, or 0 at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Take a trap this cycle |
| trap_type_i | input | 9 | Trap type of the request |
| done_i | input | 1 | Done-return strobe |
| retry_i | input | 1 | Retry-return strobe |
| pc_i | input | PC_W | Current program counter |
| npc_i | input | PC_W | Current next program counter |
| cc_i | input | CC_W | Current condition codes |
| asi_i | input | 8 | Current address-space identifier |
| pstate_i | input | 12 | Current processor state |
| cwp_i | input | 8 | Current window pointer |
| tba_i | input | PC_W | Current trap base address |
| upd_o | output | 1 | New state valid pulse |
| pc_o | output | PC_W | New program counter |
| npc_o | output | PC_W | New next program counter |
| cc_o | output | CC_W | New condition codes |
| asi_o | output | 8 | New address-space identifier |
| pstate_o | output | 12 | New processor state |
| cwp_o | output | 8 | New window pointer |
| tba_o | output | PC_W | New trap base / vector |
| tl_o | output | $clog2(MAX_TL+1) | Current trap level |
| tt_o | output | 9 | Trap type at the top level |
| err_o | output | 1 | Sticky error-state flag |
| illegal_o | output | 1 | Illegal-return pulse |

## Verification
The bench builds the block with MAX_TL=4, PC_W=32 and CC_W=8. This shallow stack lets it fill every level and reach both the reset-error-state threshold (levels 3 and 4) and the overflow at level 4, then unwind each level with alternating done and retry. At level 0 it sweeps all 512 trap types with a retry after each one, which checks every trap-type position in the vector arithmetically. Coinciding strobes and returns on an empty stack are also driven.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int ASI_W = 8;
  localparam int PS_W  = 12;
  localparam int CWP_W = 8;
  localparam int TT_W  = 9;
  localparam int VEC_TL_BIT = 14;
  localparam int VEC_TT_LSB = 5;
  localparam logic [PS_W-1:0] PS_AG   = 12'h001;
  localparam logic [PS_W-1:0] PS_PRIV = 12'h004;
  localparam logic [PS_W-1:0] PS_PEF  = 12'h010;
  localparam logic [PS_W-1:0] PS_RED  = 12'h020;

  typedef enum logic [1:0] {OP_NONE, OP_TRAP, OP_DONE, OP_RETRY} trap_op_e;
endpackage

// File: rtl/trap_op_sel.sv
module trap_op_sel
  import trap_pkg::*;
#(
  parameter int MAX_TL = 5,
  localparam int TL_W = $clog2(MAX_TL + 1)
) (
  input  logic            trap_i,
  input  logic            done_i,
  input  logic            retry_i,
  input  logic [TL_W-1:0] tl_i,
  output trap_op_e        op_o,
  output logic            full_o,
  output logic            empty_o
);
  logic at_max, at_zero;
  assign at_max  = (tl_i == TL_W'(MAX_TL));
  assign at_zero = (tl_i == '0);

  always_comb begin
    op_o = OP_NONE;
    if (trap_i) begin
      if (!at_max) op_o = OP_TRAP;
    end else if (done_i || retry_i) begin
      if (!at_zero) op_o = done_i ? OP_DONE : OP_RETRY;
    end
  end

  assign full_o  = trap_i && at_max;
  assign empty_o = !trap_i && (done_i || retry_i) && at_zero;
endmodule

// File: rtl/trap_level_store.sv
module trap_level_store
  import trap_pkg::*;
#(
  parameter int MAX_TL = 5,
  parameter int PC_W   = 32,
  parameter int SW_W   = 40,
  localparam int IDX_W = (MAX_TL > 1) ? $clog2(MAX_TL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [SW_W-1:0]  wr_word_i,
  input  logic [PC_W-1:0]  wr_pc_i,
  input  logic [PC_W-1:0]  wr_npc_i,
  input  logic [TT_W-1:0]  wr_tt_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [SW_W-1:0]  rd_word_o,
  output logic [PC_W-1:0]  rd_pc_o,
  output logic [PC_W-1:0]  rd_npc_o,
  output logic [TT_W-1:0]  rd_tt_o
);
  logic [SW_W-1:0] word_q [MAX_TL];
  logic [PC_W-1:0] pc_q   [MAX_TL];
  logic [PC_W-1:0] npc_q  [MAX_TL];
  logic [TT_W-1:0] tt_q   [MAX_TL];

  for (genvar e = 0; e < MAX_TL; e++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[e] <= '0;
        pc_q[e]   <= '0;
        npc_q[e]  <= '0;
        tt_q[e]   <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(e)) begin
        word_q[e] <= wr_word_i;
        pc_q[e]   <= wr_pc_i;
        npc_q[e]  <= wr_npc_i;
        tt_q[e]   <= wr_tt_i;
      end
    end
  end

  logic rd_ok;
  assign rd_ok     = (32'(rd_idx_i) < MAX_TL);
  assign rd_word_o = rd_ok ? word_q[rd_idx_i] : '0;
  assign rd_pc_o   = rd_ok ? pc_q[rd_idx_i]   : '0;
  assign rd_npc_o  = rd_ok ? npc_q[rd_idx_i]  : '0;
  assign rd_tt_o   = rd_ok ? tt_q[rd_idx_i]   : '0;
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_pkg::*;
#(
  parameter int MAX_TL = 5,
  parameter int PC_W   = 32,
  localparam int TL_W  = $clog2(MAX_TL + 1)
) (
  input  logic [PC_W-1:0] tba_i,
  input  logic [TT_W-1:0] tt_i,
  input  logic [TL_W-1:0] tl_i,
  output logic [PC_W-1:0] vec_o,
  output logic [PS_W-1:0] ps_o
);
  logic nested;
  assign nested = (tl_i > TL_W'(1));

  always_comb begin
    vec_o = tba_i;
    vec_o[VEC_TL_BIT:0] = '0;
    vec_o[VEC_TL_BIT] = nested;
    vec_o[VEC_TT_LSB +: TT_W] = tt_i;
  end

  // reset-error state once the stack is about to saturate
  assign ps_o = PS_AG | PS_PRIV | PS_PEF |
                ((32'(tl_i) >= MAX_TL - 1) ? PS_RED : '0);
endmodule

// File: rtl/trap_stack.sv
module trap_stack
  import trap_pkg::*;
#(
  parameter int MAX_TL = 5,
  parameter int PC_W   = 32,
  parameter int CC_W   = 8,
  localparam int TL_W  = $clog2(MAX_TL + 1),
  localparam int IDX_W = (MAX_TL > 1) ? $clog2(MAX_TL) : 1,
  localparam int SW_W  = CC_W + 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_i,
  input  logic [8:0]       trap_type_i,
  input  logic             done_i,
  input  logic             retry_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  npc_i,
  input  logic [CC_W-1:0]  cc_i,
  input  logic [7:0]       asi_i,
  input  logic [11:0]      pstate_i,
  input  logic [7:0]       cwp_i,
  input  logic [PC_W-1:0]  tba_i,
  output logic             upd_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  npc_o,
  output logic [CC_W-1:0]  cc_o,
  output logic [7:0]       asi_o,
  output logic [11:0]      pstate_o,
  output logic [7:0]       cwp_o,
  output logic [PC_W-1:0]  tba_o,
  output logic [TL_W-1:0]  tl_o,
  output logic [8:0]       tt_o,
  output logic             err_o,
  output logic             illegal_o
);
  logic [TL_W-1:0] tl_q;
  trap_op_e        op;
  logic            full, empty;
  logic [SW_W-1:0] sv_word, rd_word;
  logic [PC_W-1:0] rd_pc, rd_npc, vec;
  logic [TT_W-1:0] rd_tt;
  logic [PS_W-1:0] ps_new;
  logic [IDX_W-1:0] rd_idx;

  assign sv_word = {cc_i, asi_i, 4'b0, pstate_i, cwp_i};
  assign rd_idx  = IDX_W'(tl_q - TL_W'(1));

  trap_op_sel #(.MAX_TL(MAX_TL)) u_sel (
    .trap_i(trap_i), .done_i(done_i), .retry_i(retry_i), .tl_i(tl_q),
    .op_o(op), .full_o(full), .empty_o(empty)
  );

  trap_level_store #(.MAX_TL(MAX_TL), .PC_W(PC_W), .SW_W(SW_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(op == OP_TRAP), .wr_idx_i(IDX_W'(tl_q)),
    .wr_word_i(sv_word), .wr_pc_i(pc_i), .wr_npc_i(npc_i), .wr_tt_i(trap_type_i),
    .rd_idx_i(rd_idx), .rd_word_o(rd_word), .rd_pc_o(rd_pc),
    .rd_npc_o(rd_npc), .rd_tt_o(rd_tt)
  );

  trap_vec_gen #(.MAX_TL(MAX_TL), .PC_W(PC_W)) u_vec (
    .tba_i(tba_i), .tt_i(trap_type_i), .tl_i(tl_q), .vec_o(vec), .ps_o(ps_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tl_q <= '0; upd_o <= 1'b0; pc_o <= '0; npc_o <= '0; cc_o <= '0;
      asi_o <= '0; pstate_o <= '0; cwp_o <= '0; tba_o <= '0;
      err_o <= 1'b0; illegal_o <= 1'b0;
    end else begin
      upd_o     <= (op != OP_NONE);
      err_o     <= err_o | full;
      illegal_o <= empty;
      unique case (op)
        OP_TRAP: begin
          pc_o <= vec; npc_o <= vec + PC_W'(4); tba_o <= vec;
          pstate_o <= ps_new; cc_o <= cc_i; asi_o <= asi_i; cwp_o <= cwp_i;
          tl_q <= tl_q + TL_W'(1);
        end
        OP_DONE, OP_RETRY: begin
          if (op == OP_DONE) begin
            pc_o <= rd_npc; npc_o <= rd_npc + PC_W'(4);
          end else begin
            pc_o <= rd_pc;  npc_o <= rd_npc;
          end
          cc_o     <= rd_word[SW_W-1:32];
          asi_o    <= rd_word[31:24];
          pstate_o <= rd_word[19:8];
          cwp_o    <= rd_word[7:0];
          tl_q     <= tl_q - TL_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign tl_o = tl_q;
  assign tt_o = (tl_q == '0) ? '0 : rd_tt;

  AST_TL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tl_q) <= MAX_TL);  // R6
  AST_TRAP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && 32'(tl_q) < MAX_TL |=> tl_q == $past(tl_q) + TL_W'(1));  // R6
  AST_ENTRY_NPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && 32'(tl_q) < MAX_TL |=> npc_o == pc_o + PC_W'(4));  // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);  // R7
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && 32'(tl_q) == MAX_TL |=> err_o && !upd_o && $stable(tl_q));  // R7
  AST_RET_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_i && (done_i || retry_i) && tl_q != '0 |=> tl_q == $past(tl_q) - TL_W'(1));  // R10
  AST_EMPTY_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> tl_q == '0 && !upd_o);  // R11
endmodule

// File: tb/trap_stack_tb_top.sv
module trap_stack_tb_top;
  localparam int MAX = 4;
  localparam int PW  = 32;
  localparam int CW  = 8;

  logic clk_i = 0, rst_ni = 0;
  logic trap_i = 0, done_i = 0, retry_i = 0;
  logic [8:0] trap_type_i = 0;
  logic [PW-1:0] pc_i = 0, npc_i = 0, tba_i = 0;
  logic [CW-1:0] cc_i = 0;
  logic [7:0] asi_i = 0, cwp_i = 0;
  logic [11:0] pstate_i = 0;
  logic upd_o, err_o, illegal_o;
  logic [PW-1:0] pc_o, npc_o, tba_o;
  logic [CW-1:0] cc_o;
  logic [7:0] asi_o, cwp_o;
  logic [11:0] pstate_o;
  logic [2:0] tl_o;
  logic [8:0] tt_o;

  always #10 clk_i = ~clk_i;

  trap_stack #(.MAX_TL(MAX), .PC_W(PW), .CC_W(CW)) dut_i (.*);

  int n_run = 0, n_fail = 0;
  bit fin = 0;
  int m_tl = 0;
  logic [39:0] m_ts [MAX];
  logic [PW-1:0] m_pc [MAX], m_npc [MAX];
  logic [8:0] m_tt [MAX];
  logic [PW-1:0] m_tba = 0;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic do_trap(logic [8:0] tt, logic [PW-1:0] pc, logic [PW-1:0] npc,
                         logic [7:0] cc, logic [7:0] asi, logic [11:0] ps,
                         logic [7:0] cwp, logic [PW-1:0] base, bit with_done);
    logic [PW-1:0] v;
    logic [11:0] pe;
    trap_type_i = tt; pc_i = pc; npc_i = npc; cc_i = cc; asi_i = asi;
    pstate_i = ps; cwp_i = cwp; tba_i = base;
    trap_i = 1; done_i = with_done; retry_i = with_done;
    step();
    trap_i = 0; done_i = 0; retry_i = 0;
    if (m_tl == MAX) begin
      chk("R7 err", 64'(err_o), 1);
      chk("R7 upd", 64'(upd_o), 0);
      chk("R7 tl", 64'(tl_o), MAX);
    end else begin
      v = {base[PW-1:15], (m_tl > 1) ? 1'b1 : 1'b0, tt, 5'b0};
      pe = 12'h015 | ((m_tl >= MAX - 1) ? 12'h020 : 12'h000);
      m_ts[m_tl] = {cc, asi, 4'b0, ps, cwp};
      m_pc[m_tl] = pc; m_npc[m_tl] = npc; m_tt[m_tl] = tt;
      m_tl++; m_tba = v;
      chk("R6 upd", 64'(upd_o), 1);
      chk("R6 tl", 64'(tl_o), 64'(m_tl));
      chk("R4 vec", 64'(tba_o), 64'(v));
      chk("R5 pc", 64'(pc_o), 64'(v));
      chk("R5 npc", 64'(npc_o), 64'(v + 4));
      chk("R5 pass", {cc_o, asi_o, cwp_o}, {cc, asi, cwp});
      chk("R3 pstate", 64'(pstate_o), 64'(pe));
      chk("R13 tt", 64'(tt_o), 64'(tt));
      if (with_done) chk("R12 trap wins", 64'(tl_o), 64'(m_tl));
    end
  endtask

  task automatic do_ret(bit is_done, bit both);
    int i;
    done_i = is_done; retry_i = !is_done || both;
    step();
    done_i = 0; retry_i = 0;
    if (m_tl == 0) begin
      chk("R11 illegal", 64'(illegal_o), 1);
      chk("R11 upd", 64'(upd_o), 0);
      chk("R11 tl", 64'(tl_o), 0);
    end else begin
      i = m_tl - 1;
      m_tl--;
      if (is_done) begin
        chk(both ? "R12 done wins pc" : "R8 pc", 64'(pc_o), 64'(m_npc[i]));
        chk("R8 npc", 64'(npc_o), 64'(m_npc[i] + 4));
      end else begin
        chk("R9 pc", 64'(pc_o), 64'(m_pc[i]));
        chk("R9 npc", 64'(npc_o), 64'(m_npc[i]));
      end
      chk("R10 R2 word", {cc_o, asi_o, 4'b0, pstate_o, cwp_o}, 64'(m_ts[i]));
      chk("R10 tl", 64'(tl_o), 64'(m_tl));
      chk("R10 tba", 64'(tba_o), 64'(m_tba));
      chk("R13 tt", 64'(tt_o), (m_tl == 0) ? 64'd0 : 64'(m_tt[m_tl-1]));
      chk("R11 no illegal", 64'(illegal_o), 0);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 reset", {tl_o, upd_o, err_o, illegal_o, pstate_o, cc_o},
        64'd0);
    chk("R1 reset pc", {pc_o, npc_o}, 64'd0);
    rst_ni = 1;
    @(negedge clk_i);
    do_ret(1, 0);                       // R11 empty return
    for (int k = 0; k < MAX; k++)
      do_trap(9'(k * 37 + 5), 32'h1000 + 32'(k) * 16, 32'h1004 + 32'(k) * 16,
              8'(8'hA0 + k), 8'(8'h80 + k * 3), 12'(12'h9C3 ^ k),
              8'(k + 1), 32'hDEAD_7FFF ^ (32'(k) << 20), 0);
    do_trap(9'h1FF, 32'h5, 32'h9, 8'h1, 8'h2, 12'h3, 8'h4, 32'hFFFF_FFFF, 0); // R7
    for (int k = 0; k < MAX; k++) do_ret(k[0], 0);
    do_ret(0, 0);                       // R11 again
    do_trap(9'h0AA, 32'h2000, 32'h2004, 8'h55, 8'h66, 12'h777, 8'h88, 32'h0001_8000, 1); // R12
    do_trap(9'h011, 32'h3000, 32'h3004, 8'h12, 8'h34, 12'h567, 8'h09, 32'h0000_0000, 0);
    do_ret(1, 1);                       // R12 done over retry
    do_ret(0, 0);
    for (int t = 0; t < 512; t++) begin // sweep of trap types
      do_trap(9'(t), 32'(t) * 8, 32'(t) * 8 + 4, 8'(t), 8'(t >> 1), 12'(t * 7),
              8'(t ^ 8'h5A), 32'(t) << 15 | 32'h7FFF, 0);
      do_ret(0, 0);
    end
    chk("R7 sticky", 64'(err_o), 1);
    fin = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule